// File: doc/BRIEF.md
# Byte-Wide Static Memory Core with Sleep Control

This block is a clocked, synthesizable model of a byte-wide static memory. It has four active-low controls: chip select, write enable, output enable and sleep. A combinational decoder turns these controls into one of four operating modes: read, write, deselected or asleep. The mode decides which input paths may change stored state and whether the data drivers are enabled. The bidirectional data bus is split into a data-in bus, a data-out bus and one driver-enable bit. A pad ring above the block joins them into a tri-state pin.

Reads are registered and have one cycle of latency. Writes commit in one of two ways, chosen by a parameter:
- On every clock edge where the write mode holds.
- At the clock edge that first sees write enable released. This commits the address and data held from the last write cycle.

A second parameter removes the sleep option, and the sleep input is then treated as permanently inactive. The port carries a 19-bit word address. Only the low `MEM_AW` address bits reach the storage array, so a small array can stand in for the full address space.

Top module: `sram_sleep_core`

## Requirements
- R1: While reset is asserted, `dq_oe` is 0 and `dq_out` is 0, whatever the controls are.
- R2: In read mode (`cs_n`=0, `sl_n`=1, `we_n`=1) with `oe_n`=0, `dq_oe` is 1 in the same cycle. After the next rising clock edge, `dq_out` holds the word stored at the address sampled at that edge.
- R3: In level-capture mode (`EDGE_WR`=0), `cs_n`=0, `sl_n`=1 and `we_n`=0 store `dq_in` at the addressed word on each rising edge. `dq_oe` stays 0 even with `oe_n`=0.
- R4: With `cs_n`=1 and the block awake, `dq_oe` is 0 and no word changes, even with `we_n`=0.
- R5: With sleep fitted and `sl_n`=0, `dq_oe` is 0 and no word changes, whatever the other controls are.
- R6: `oe_n`=1 forces `dq_oe` to 0 for any value of `cs_n`, `we_n` and `sl_n`.
- R7: Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R8: With sleep left out (`HAS_SLEEP`=0), `sl_n` has no effect: reads and writes behave the same with `sl_n`=0.
- R9: In edge-capture mode (`EDGE_WR`=1), address and data are sampled on each write-mode edge. The last sampled pair is committed at the first edge in read mode that follows a write-mode edge. A write that ends through deselect or sleep is dropped.
- R10: In edge-capture mode, a read at the commit edge to the committed address returns the newly committed data.
- R11: Stored words keep their values across sleep and deselect periods.
- R12: Only the low `MEM_AW` address bits select a word. Two addresses that differ only above bit `MEM_AW`-1 reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; high forces drivers off |
| sl_n | input | 1 | Sleep, active low; ignored when sleep is not fitted |
| addr | input | ADDR_W (19) | Word address |
| dq_in | input | DATA_W (8) | Write data from the pad |
| dq_out | output | DATA_W (8) | Read data toward the pad |
| dq_oe | output | 1 | Data pad driver enable |

## Verification
The bench builds two copies side by side, both with an 8-bit array behind the 19-bit address, so aliasing of high address bits can be observed.

The first copy uses level capture with sleep fitted. It runs the mode table, the driver gating, retention across sleep and deselect, and the aliasing checks.

The second copy uses edge capture with sleep left out. Its directed sequences show three behaviours:
- A held-low sleep input is ignored.
- Only the last data of a multi-cycle write is committed, and it is forwarded to a read at the commit edge.
- A write cut short by deselect never lands.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_WRITE = 2'd1,
    MD_DESEL = 2'd2,
    MD_SLEEP = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
#(
  parameter bit HAS_SLEEP = 1'b1
) (
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       sl_n,
  output sram_mode_e mode,
  output logic       rd_req,
  output logic       wr_req
);

  logic awake;

  generate
    if (HAS_SLEEP) begin : g_sleep
      assign awake = sl_n;
    end else begin : g_nosleep
      logic unused_sl;
      assign unused_sl = sl_n;
      assign awake     = 1'b1;
    end
  endgenerate

  // Sleep outranks every other control, chip select outranks write enable.
  always_comb begin
    if (!awake) begin
      mode = MD_SLEEP;
    end else if (cs_n) begin
      mode = MD_DESEL;
    end else if (!we_n) begin
      mode = MD_WRITE;
    end else begin
      mode = MD_READ;
    end
  end

  assign rd_req = (mode == MD_READ);
  assign wr_req = (mode == MD_WRITE);

endmodule

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter bit EDGE_WR = 1'b1
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);

  generate
    if (EDGE_WR) begin : g_edge
      logic [AW-1:0] a_q, a_d;
      logic [DW-1:0] d_q, d_d;
      logic          wp_q, wp_d;

      // Address/data registers load only in write mode and hold otherwise.
      always_comb begin
        a_d  = a_q;
        d_d  = d_q;
        wp_d = wr_req;
        if (wr_req) begin
          a_d = addr;
          d_d = din;
        end
      end

      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) begin
          a_q  <= '0;
          d_q  <= '0;
          wp_q <= 1'b0;
        end else begin
          a_q  <= a_d;
          d_q  <= d_d;
          wp_q <= wp_d;
        end
      end

      // Commit when write enable has been released with the chip awake and selected.
      assign wr_en   = wp_q && rd_req;
      assign wr_addr = a_q;
      assign wr_data = d_q;
    end else begin : g_level
      logic unused_lvl;
      assign unused_lvl = clk ^ rd_req;
      assign wr_en      = wr_req && rst_ok;
      assign wr_addr    = addr;
      assign wr_data    = din;
    end
  endgenerate

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ok,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_d;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Read register loads only on read cycles; a same-edge commit is forwarded.
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      if (wr_en && (wr_addr == rd_addr)) begin
        rd_d = wr_data;
      end else begin
        rd_d = mem[rd_addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

endmodule

// File: rtl/sram_sleep_core.sv
module sram_sleep_core
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int MEM_AW    = 8,
  parameter bit HAS_SLEEP = 1'b1,
  parameter bit EDGE_WR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              sl_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  localparam int HI_W = ADDR_W - MEM_AW;

  sram_mode_e        mode;
  logic              rd_req;
  logic              wr_req;
  logic              rst_ok;
  logic              wr_en;
  logic [MEM_AW-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_q;
  logic [MEM_AW-1:0] a_lo;
  logic              rd_en;

  assign a_lo = addr[MEM_AW-1:0];

  generate
    if (HI_W > 0) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:MEM_AW];
    end
  endgenerate

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  sram_mode_dec #(.HAS_SLEEP(HAS_SLEEP)) u_dec (
    .cs_n   (cs_n),
    .we_n   (we_n),
    .sl_n   (sl_n),
    .mode   (mode),
    .rd_req (rd_req),
    .wr_req (wr_req)
  );

  sram_wr_capture #(.AW(MEM_AW), .DW(DATA_W), .EDGE_WR(EDGE_WR)) u_cap (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .wr_req  (wr_req),
    .rd_req  (rd_req),
    .addr    (a_lo),
    .din     (dq_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign rd_en = rd_req && rst_ok;

  sram_array #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk     (clk),
    .rst_ok  (rst_ok),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (a_lo),
    .rd_q    (rd_q)
  );

  logic unused_mode;
  assign unused_mode = ^mode;

  assign dq_oe  = rd_req && !oe_n && rst_ok;
  assign dq_out = dq_oe ? rd_q : '0;

endmodule

// File: rtl/sram_sleep_core_chk.sv
module sram_sleep_core_chk #(
  parameter int DATA_W    = 8,
  parameter bit HAS_SLEEP = 1'b1
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              sl_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  logic awake;
  assign awake = !HAS_SLEEP || sl_n;

  // R6
  oe_high_hiz_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    oe_n |-> !dq_oe);

  // R5
  sleep_hiz_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !awake |-> !dq_oe);

  // R4
  desel_hiz_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |-> !dq_oe);

  // R3
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cs_n && !we_n) |-> !dq_oe);

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !dq_oe |-> (dq_out == '0));

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (awake && !cs_n && we_n && !oe_n) |-> dq_oe);

endmodule

bind sram_sleep_core sram_sleep_core_chk #(
  .DATA_W    (DATA_W),
  .HAS_SLEEP (HAS_SLEEP)
) u_chk (
  .clk    (clk),
  .rst_ok (rst_ok),
  .cs_n   (cs_n),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .sl_n   (sl_n),
  .dq_out (dq_out),
  .dq_oe  (dq_oe)
);

// File: tb/sram_sleep_core_tb.sv
module sram_sleep_core_tb;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int NV = 13;

  typedef struct packed {
    logic          cs_n;
    logic          we_n;
    logic          oe_n;
    logic          sl_n;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          eoe;
    logic [DW-1:0] edq;
    logic [7:0]    req;
  } vec_t;

  // Table for the level-capture copy with sleep fitted.
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 19'h00010, 8'hA5, 1'b0, 8'h00, 8'd3},  // R3 write, oe low ignored
    '{1'b0, 1'b0, 1'b1, 1'b1, 19'h00011, 8'h3C, 1'b0, 8'h00, 8'd3},  // R3 write
    '{1'b0, 1'b1, 1'b0, 1'b1, 19'h00010, 8'h00, 1'b1, 8'hA5, 8'd2},  // R2 read
    '{1'b0, 1'b1, 1'b0, 1'b1, 19'h00011, 8'h00, 1'b1, 8'h3C, 8'd2},  // R2 read
    '{1'b0, 1'b1, 1'b1, 1'b1, 19'h00010, 8'h00, 1'b0, 8'h00, 8'd6},  // R6 / R7
    '{1'b1, 1'b0, 1'b0, 1'b1, 19'h00010, 8'hFF, 1'b0, 8'h00, 8'd4},  // R4 deselected write
    '{1'b0, 1'b1, 1'b0, 1'b1, 19'h00010, 8'h00, 1'b1, 8'hA5, 8'd4},  // R4 word unchanged
    '{1'b0, 1'b0, 1'b0, 1'b0, 19'h00011, 8'h00, 1'b0, 8'h00, 8'd5},  // R5 sleep with write controls
    '{1'b0, 1'b1, 1'b0, 1'b0, 19'h00011, 8'h00, 1'b0, 8'h00, 8'd5},  // R5 sleep with read controls
    '{1'b0, 1'b1, 1'b0, 1'b1, 19'h00011, 8'h00, 1'b1, 8'h3C, 8'd11}, // R11 retained after sleep
    '{1'b0, 1'b0, 1'b0, 1'b1, 19'h00005, 8'h5A, 1'b0, 8'h00, 8'd3},  // R3 write
    '{1'b0, 1'b1, 1'b0, 1'b1, 19'h40005, 8'h00, 1'b1, 8'h5A, 8'd12}, // R12 alias
    '{1'b1, 1'b1, 1'b0, 1'b1, 19'h00010, 8'h00, 1'b0, 8'h00, 8'd4}   // R4 deselected read
  };

  logic          clk;
  logic          rst_n;
  logic          cs_n, we_n, oe_n, sl_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out, dq_out_e;
  logic          dq_oe, dq_oe_e;

  int total;
  int bad;
  bit done;

  sram_sleep_core #(
    .ADDR_W(AW), .DATA_W(DW), .MEM_AW(8), .HAS_SLEEP(1'b1), .EDGE_WR(1'b0)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .sl_n(sl_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  sram_sleep_core #(
    .ADDR_W(AW), .DATA_W(DW), .MEM_AW(8), .HAS_SLEEP(1'b0), .EDGE_WR(1'b1)
  ) u_dut_e (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .sl_n(sl_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out_e), .dq_oe(dq_oe_e)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual oe/dq=%h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic o, input logic s,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; sl_n = s; addr = a; dq_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; sl_n = 1'b1;
    addr = '0; dq_in = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: read controls applied while in reset
    check("R1 oe", {dq_oe, 8'h00}, {1'b0, 8'h00});
    check("R1 dq", {1'b0, dq_out}, {1'b0, 8'h00});
    check("R1 oe edge copy", {dq_oe_e, 8'h00}, {1'b0, 8'h00});
    check("R1 dq edge copy", {1'b0, dq_out_e}, {1'b0, 8'h00});
    @(negedge clk);
    rst_n = 1'b1;
    cs_n  = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].cs_n, VT[i].we_n, VT[i].oe_n, VT[i].sl_n, VT[i].a, VT[i].d);
      check($sformatf("R%0d vec%0d oe", VT[i].req, i), {dq_oe, 8'h00}, {VT[i].eoe, 8'h00});
      check($sformatf("R%0d vec%0d dq", VT[i].req, i), {1'b0, dq_out}, {1'b0, VT[i].edq});
    end

    // Edge-capture copy, sleep held low to show it is ignored (R8).
    drive(1'b0, 1'b0, 1'b0, 1'b0, 19'h00020, 8'h11);
    check("R9 no drive during write", {dq_oe_e, 8'h00}, {1'b0, 8'h00});
    drive(1'b0, 1'b1, 1'b0, 1'b0, 19'h00020, 8'h00);
    check("R8 sleep ignored oe", {dq_oe_e, 8'h00}, {1'b1, 8'h00});
    check("R10 forwarded read", {1'b0, dq_out_e}, {1'b0, 8'h11});
    check("R5 fitted copy asleep", {dq_oe, dq_out}, {1'b0, 8'h00});
    sl_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 19'h00021, 8'h99);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 19'h00021, 8'h22);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 19'h00021, 8'h00);
    check("R9 last data committed", {dq_oe_e, dq_out_e}, {1'b1, 8'h22});
    drive(1'b0, 1'b0, 1'b0, 1'b1, 19'h00021, 8'h77);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 19'h00021, 8'h00);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 19'h00021, 8'h00);
    check("R9 aborted write dropped", {dq_oe_e, dq_out_e}, {1'b1, 8'h22});
    drive(1'b0, 1'b1, 1'b0, 1'b1, 19'h00020, 8'h00);
    check("R11 edge copy retained", {dq_oe_e, dq_out_e}, {1'b1, 8'h11});
    drive(1'b0, 1'b1, 1'b0, 1'b1, 19'h00010, 8'h00);
    check("R11 fitted copy retained", {dq_oe, dq_out}, {1'b1, 8'hA5});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule